// File: doc/BRIEF.md
# Line-Doubled Raster Scanout Engine

This block drives a VGA-style monitor from a small frame buffer. A free-running horizontal counter sets the line period and places the horizontal sync pulse. A vertical phase machine advances once per line through back porch, visible region, front porch and sync, and then returns to back porch. On every visible line a fixed-length burst of reads fetches one buffer row through a synchronous read port. The bytes leave as a pixel stream. Once the burst ends, the stream returns to zero (black).

Each buffer row appears on two successive display lines. The row pointer is reloaded with the frame base when the visible region starts. It steps by one row length only on lines whose new number is even, and it wraps to the base when it reaches the end of the frame. All timing constants and the buffer geometry are parameters.

The pixel stream carries a valid flag but has no ready input, because raster timing cannot stall. The sink must take every beat on the cycle it is marked valid. The read port likewise has no stall: data requested in one cycle must be presented on the next cycle.

Top module: `lowres_scanout`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `hsync` and `vsync` are high, `pix_data` is 0, and `pix_valid` and `fb_rd_en` are 0.
- R2: The horizontal position counts 0 to H_TOTAL-1 and then repeats. It is 0 in the first cycle after reset. `hsync` is low in a cycle exactly when the previous cycle's position lay in [HS_START, HS_END); it is active low by default.
- R3: A line counter starts at 0 in back porch and advances at each line end. The phase enters visible, front porch and sync when the new count reaches VISIBLE_START, VFP_START and VSYNC_START. When the count reaches VSYNC_END the phase returns to back porch with the count at 0, so a frame spans VSYNC_END lines.
- R4: `vsync` goes low at the line end that follows the entry to sync, and high again at the line end that follows the exit from sync. It therefore lags the sync phase by one line.
- R5: On a visible line, `fb_rd_en` is high for exactly PIX_PER_LINE cycles, at positions BURST_START+1 to BURST_START+PIX_PER_LINE. `fb_rd_addr` runs upward by one per cycle from the current row address.
- R6: The read port returns data one cycle after a request. Each fetched byte appears on `pix_data` with `pix_valid` high two cycles after its request, in order, with none lost or repeated.
- R7: Whenever `pix_valid` is low, `pix_data` is 0. This covers the cycle right after each burst and all blanking lines.
- R8: On entry to the visible region the row address is reloaded with FB_BASE, whatever row the previous frame ended on.
- R9: Within the visible region the row address advances by LINE_LEN only at a line end whose new line number is even, so each row is shown on two lines.
- R10: If the advanced row address would reach FB_BASE+FRAME_SIZE, it becomes FB_BASE instead.
- R11: No read request is made on lines outside the visible region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_rd_en | output | 1 | Frame buffer read request |
| fb_rd_addr | output | ADDR_W | Frame buffer read address |
| fb_rd_data | input | PIX_W | Read data, valid one cycle after the request |
| pix_data | output | PIX_W | Pixel byte, 0 when not valid |
| pix_valid | output | 1 | Marks a burst pixel; no back-pressure |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
Two functions can fall on the same line-end edge. The row step for an even line can coincide with the exit from the visible region, and the row step can coincide with the wrap to the base. The bench picks an even VFP_START and a frame of three rows over ten visible lines, so that over several frames both collisions occur. The scoreboard then judges the outcome from the read addresses of every visible line: no reads may happen on the line after the visible region ends, and each new frame must restart at the base row rather than a wrapped or advanced one.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
  typedef enum logic [1:0] {
    VP_BACK  = 2'd0,
    VP_SHOW  = 2'd1,
    VP_FRONT = 2'd2,
    VP_SYNC  = 2'd3
  } vphase_t;
endpackage

// File: rtl/scan_line_timer.sv
module scan_line_timer #(
  parameter int H_TOTAL  = 400,
  parameter int HS_START = 328,
  parameter int HS_END   = 376,
  parameter bit ACT_LOW  = 1'b1,
  localparam int HW = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hpos,
  output logic          line_end,
  output logic          hsync
);
  localparam logic [HW-1:0] LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] HS_A = HW'(HS_START);
  localparam logic [HW-1:0] HS_B = HW'(HS_END);

  logic hs_on;

  assign line_end = (hpos == LAST);
  assign hsync    = hs_on ^ ACT_LOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos  <= '0;
      hs_on <= 1'b0;
    end else begin
      hpos  <= line_end ? '0 : hpos + 1'b1;
      hs_on <= (hpos >= HS_A) && (hpos < HS_B);
    end
  end

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_end) |-> hpos == '0);
endmodule

// File: rtl/scan_vert_fsm.sv
module scan_vert_fsm
  import scanout_pkg::*;
#(
  parameter int VISIBLE_START = 34,
  parameter int VFP_START     = 274,
  parameter int VSYNC_START   = 284,
  parameter int VSYNC_END     = 286,
  parameter int ADDR_W        = 16,
  parameter int FB_BASE       = 0,
  parameter int LINE_LEN      = 160,
  parameter int FRAME_SIZE    = 19200,
  parameter bit ACT_LOW       = 1'b1,
  localparam int LW = $clog2(VSYNC_END + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  output vphase_t           phase,
  output logic [ADDR_W-1:0] row_addr,
  output logic              vsync
);
  localparam logic [LW-1:0]     L_VIS  = LW'(VISIBLE_START);
  localparam logic [LW-1:0]     L_FP   = LW'(VFP_START);
  localparam logic [LW-1:0]     L_SS   = LW'(VSYNC_START);
  localparam logic [LW-1:0]     L_SE   = LW'(VSYNC_END);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FB_BASE);
  localparam logic [ADDR_W-1:0] LIM_A  = ADDR_W'(FB_BASE + FRAME_SIZE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(LINE_LEN);

  logic [LW-1:0]     lcnt, lnext;
  logic [ADDR_W-1:0] row_step, row_wrap;
  logic              vs_tgt, vs_on;

  assign lnext    = lcnt + 1'b1;
  assign row_step = row_addr + STEP_A;
  assign row_wrap = (row_step >= LIM_A) ? BASE_A : row_step;
  assign vsync    = vs_on ^ ACT_LOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= VP_BACK;
      lcnt     <= '0;
      row_addr <= BASE_A;
      vs_tgt   <= 1'b0;
      vs_on    <= 1'b0;
    end else if (line_end) begin
      vs_on <= vs_tgt;
      lcnt  <= lnext;
      case (phase)
        VP_BACK: if (lnext >= L_VIS) begin
          phase    <= VP_SHOW;
          row_addr <= BASE_A;
        end
        VP_SHOW: begin
          if (lnext >= L_FP) phase <= VP_FRONT;
          else if (!lnext[0]) row_addr <= row_wrap;
        end
        VP_FRONT: if (lnext >= L_SS) begin
          phase  <= VP_SYNC;
          vs_tgt <= 1'b1;
        end
        default: if (lnext >= L_SE) begin
          phase  <= VP_BACK;
          lcnt   <= '0;
          vs_tgt <= 1'b0;
        end
      endcase
    end
  end

  assert_row_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == VP_SHOW) |-> row_addr == BASE_A);
  assert_row_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr >= BASE_A) && (row_addr < LIM_A));
  assert_vsync_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_on) |-> $past(phase) == VP_SYNC);
endmodule

// File: rtl/scan_burst_reader.sv
module scan_burst_reader #(
  parameter int PIX_PER_LINE = 160,
  parameter int ADDR_W       = 16,
  parameter int PIX_W        = 8,
  localparam int CW = $clog2(PIX_PER_LINE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid
);
  localparam logic [CW-1:0] LAST = CW'(PIX_PER_LINE - 1);

  logic          busy, rvld;
  logic [CW-1:0] cnt;

  assign rd_en = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rd_addr <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt     <= '0;
      rd_addr <= base_addr;
    end else if (busy) begin
      rd_addr <= rd_addr + 1'b1;
      cnt     <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  // Data arrives one cycle after the request; the valid flag follows it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld      <= 1'b0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      rvld      <= busy;
      pix_valid <= rvld;
      pix_data  <= rvld ? rd_data : '0;
    end
  end

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);
  assert_pix_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(rd_en, 2));
endmodule

// File: rtl/lowres_scanout.sv
module lowres_scanout
  import scanout_pkg::*;
#(
  parameter int H_TOTAL       = 400,
  parameter int BURST_START   = 8,
  parameter int PIX_PER_LINE  = 160,
  parameter int HS_START      = 328,
  parameter int HS_END        = 376,
  parameter int VISIBLE_START = 34,
  parameter int VFP_START     = 274,
  parameter int VSYNC_START   = 284,
  parameter int VSYNC_END     = 286,
  parameter int ADDR_W        = 16,
  parameter int PIX_W         = 8,
  parameter int FB_BASE       = 0,
  parameter int FRAME_SIZE    = 19200,
  parameter bit SYNC_ACT_LOW  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fb_rd_en,
  output logic [ADDR_W-1:0] fb_rd_addr,
  input  logic [PIX_W-1:0]  fb_rd_data,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid,
  output logic              hsync,
  output logic              vsync
);
  localparam int HW = $clog2(H_TOTAL);
  localparam logic [HW-1:0] BURST_POS = HW'(BURST_START);

  logic [HW-1:0]     hpos;
  logic              line_end, start;
  vphase_t           phase;
  logic [ADDR_W-1:0] row_addr;

  scan_line_timer #(
    .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_END(HS_END), .ACT_LOW(SYNC_ACT_LOW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .line_end(line_end), .hsync(hsync)
  );

  scan_vert_fsm #(
    .VISIBLE_START(VISIBLE_START), .VFP_START(VFP_START),
    .VSYNC_START(VSYNC_START), .VSYNC_END(VSYNC_END),
    .ADDR_W(ADDR_W), .FB_BASE(FB_BASE), .LINE_LEN(PIX_PER_LINE),
    .FRAME_SIZE(FRAME_SIZE), .ACT_LOW(SYNC_ACT_LOW)
  ) u_vert (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .phase(phase),
    .row_addr(row_addr), .vsync(vsync)
  );

  assign start = (phase == VP_SHOW) && (hpos == BURST_POS);

  scan_burst_reader #(
    .PIX_PER_LINE(PIX_PER_LINE), .ADDR_W(ADDR_W), .PIX_W(PIX_W)
  ) u_burst (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(row_addr),
    .rd_en(fb_rd_en), .rd_addr(fb_rd_addr), .rd_data(fb_rd_data),
    .pix_data(pix_data), .pix_valid(pix_valid)
  );

  assert_no_blank_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> phase == VP_SHOW);
endmodule

// File: tb/tb_lowres_scanout.sv
module tb_lowres_scanout;
  localparam int H = 40, B = 4, PIX = 16, HSA = 26, HSB = 32;
  localparam int VIS = 2, FP = 12, SS = 14, SE = 16;
  localparam int AW = 10, BASE = 100, FS = 48, ROWS = FS / PIX;
  localparam int RUN = 3 * SE * H + 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fb_rd_en, pix_valid, hsync, vsync;
  logic [AW-1:0] fb_rd_addr;
  logic [7:0] fb_rd_data, pix_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  lowres_scanout #(
    .H_TOTAL(H), .BURST_START(B), .PIX_PER_LINE(PIX), .HS_START(HSA), .HS_END(HSB),
    .VISIBLE_START(VIS), .VFP_START(FP), .VSYNC_START(SS), .VSYNC_END(SE),
    .ADDR_W(AW), .PIX_W(8), .FB_BASE(BASE), .FRAME_SIZE(FS), .SYNC_ACT_LOW(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
    .fb_rd_data(fb_rd_data), .pix_data(pix_data), .pix_valid(pix_valid),
    .hsync(hsync), .vsync(vsync)
  );

  function automatic logic [7:0] mem_val(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // Synchronous buffer model, one cycle of read latency.
  always @(posedge clk) if (fb_rd_en) fb_rd_data <= mem_val(int'(fb_rd_addr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: computes the expected outputs of cycle n and queues expected pixels.
  // Monitor: pops the queue as the design marks pixels valid.
  task automatic cycle(int n);
    int h = n % H, ln = n / H, k = (n / H) % SE, cnt = 0, a0;
    bit vis = (k >= VIS) && (k < FP);
    bit e_rd, e_pv;
    for (int j = VIS + 1; j <= k; j++) if (j % 2 == 0) cnt++;   // R9 doubling
    a0 = BASE + (cnt % ROWS) * PIX;                              // R10 wrap, R8 reload
    e_rd = vis && (h >= B + 1) && (h <= B + PIX);
    e_pv = vis && (h >= B + 3) && (h < B + 3 + PIX);
    chk("R2 hsync", int'(hsync),
        (n >= 1 && ((n - 1) % H) >= HSA && ((n - 1) % H) < HSB) ? 0 : 1);
    chk("R3/R4 vsync", int'(vsync), (ln >= 1 && ((ln - 1) % SE) >= SS) ? 0 : 1);
    chk(vis ? "R5 rd_en" : "R11 rd_en in blanking", int'(fb_rd_en), int'(e_rd));
    if (e_rd && fb_rd_en) chk("R5/R9/R10 rd_addr", int'(fb_rd_addr), a0 + h - B - 1);
    if (e_pv) exp_q.push_back(mem_val(a0 + h - B - 3));
    chk("R6 pix_valid", int'(pix_valid), int'(e_pv));
    if (pix_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected pixel", int'(pix_data), -1);
      else chk("R6 pixel data", int'(pix_data), int'(exp_q.pop_front()));
    end else begin
      chk("R7 zero when idle", int'(pix_data), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 hsync in reset", int'(hsync), 1);
    chk("R1 vsync in reset", int'(vsync), 1);
    chk("R1 pix in reset", int'(pix_data), 0);
    chk("R1 valid in reset", int'(pix_valid), 0);
    chk("R1 rd_en in reset", int'(fb_rd_en), 0);
    rst_n = 1'b1;
    #1;
    cycle(0);
    for (int n = 1; n <= RUN; n++) begin
      @(negedge clk);
      cycle(n);
    end
    chk("R6 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule